// File: doc/BRIEF.md
# Pointer-Based Hub Address Generator

This block turns the 9-bit address operand of a hub memory read or write into an effective hub address. The operand takes one of two forms. In the first, it carries a small absolute address in the bottom 256 bytes of hub space. In the second, it names one of two pointer registers and gives a signed 5-bit index. The index is scaled by the access size. It can leave the pointer untouched, or it can move the pointer before the access or after it.

The block holds both pointer registers. Each one has a direct load port. A pointer change caused by an access is reported on the write-back outputs in the same cycle and is committed on the next clock edge. The effective address is combinational from the current pointer contents. The memory access, instruction fetch and pipeline control belong to the surrounding logic.

Top module: `hub_ea_gen`

## Requirements
- R1: When operand bit 8 is 0, the effective address equals operand bits 7:0 zero-extended (0 to 255), and no pointer write is signalled.
- R2: When operand bit 8 is 1, operand bit 7 picks the pointer: 0 selects pointer A and 1 selects pointer B. `ptr_wsel` reports this choice.
- R3: With operand bit 6 (update flag) at 0, the effective address is the pointer plus the scaled index, `ptr_we` stays 0 and the pointer keeps its value.
- R4: With update flag 1 and operand bit 5 (post flag) 1, the effective address is the unmodified pointer. After the next clock edge the pointer holds pointer plus scaled index.
- R5: With update flag 1 and post flag 0, the effective address is pointer plus scaled index. The pointer takes that same value on the next clock edge.
- R6: Operand bits 4:0 form a two's-complement index: 5'b00001 is +1 unit and 5'b11111 is -1 unit.
- R7: The size code sets the scale: 2'b00 byte (x1), 2'b01 word (x2), 2'b10 long (x4). Code 2'b11 also scales by 4.
- R8: Pointer sums wrap modulo 2^AW (AW = 20 by default).
- R9: A load on `ld_a_en`/`ld_b_en` sets that pointer on the next edge. It wins over an access update to the same pointer in the same cycle, while the other pointer still takes its update.
- R10: When `acc_valid` is 0, `ptr_we` is 0 and neither pointer changes.
- R11: Reset clears both pointers to 0.
- R12: An access in the cycle right after a pointer update sees the updated pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe; allows a pointer update |
| acc_field | input | 9 | Address operand |
| acc_size | input | 2 | Size code: 0 byte, 1 word, 2 long, 3 treated as long |
| ld_a_en | input | 1 | Load pointer A |
| ld_a_val | input | AW | Value for pointer A |
| ld_b_en | input | 1 | Load pointer B |
| ld_b_val | input | AW | Value for pointer B |
| ea | output | AW | Effective hub address |
| ptr_we | output | 1 | Pointer write-back enable |
| ptr_wsel | output | 1 | Pointer addressed by the operand (0 A, 1 B) |
| ptr_new | output | AW | Pointer plus scaled index |

## Verification
The assertions watch several behaviours on every cycle:
- an absolute operand stays below 256 and never raises a write;
- an idle strobe never raises a write;
- a post-modify access presents the pointer it selected;
- a pre-modify write leaves the pointer equal to the address it presented;
- a load overrides an update;
- a pointer with no load and no update holds its value.

Other behaviours can only be shown by the bench's scenarios, because each needs a known pointer value and an expected sum worked out in advance:
- the exact scaled and sign-extended offsets for each size code;
- wrap-around at the top and bottom of the address space;
- the reset value;
- back-to-back chains of accesses.

// File: rtl/hub_ea_pkg.sv
package hub_ea_pkg;

    localparam int OPND_W = 9;
    localparam int IDX_W  = 5;
    localparam int ABS_W  = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic             is_ptr;
        logic             sel;
        logic             upd;
        logic             post;
        logic [IDX_W-1:0] idx;
        logic [ABS_W-1:0] abs_addr;
    } opnd_dec_t;

endpackage

// File: rtl/hub_ea_decode.sv
module hub_ea_decode
    import hub_ea_pkg::*;
(
    input  logic [OPND_W-1:0] opnd,
    output opnd_dec_t         dec
);

    always_comb begin
        dec          = '0;
        dec.is_ptr   = opnd[8];
        dec.abs_addr = opnd[ABS_W-1:0];
        if (opnd[8]) begin
            dec.sel  = opnd[7];
            dec.upd  = opnd[6];
            dec.post = opnd[5];
            dec.idx  = opnd[IDX_W-1:0];
        end
    end

endmodule

// File: rtl/hub_ea_offset.sv
module hub_ea_offset
    import hub_ea_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       size,
    output logic [AW-1:0]    off
);

    logic [AW-1:0] ext;
    logic [1:0]    sh;

    always_comb begin
        ext = {{(AW-IDX_W){idx[IDX_W-1]}}, idx};
        case (acc_size_e'(size))
            SZ_BYTE: sh = 2'd0;
            SZ_WORD: sh = 2'd1;
            default: sh = 2'd2;
        endcase
        off = ext << sh;
    end

endmodule

// File: rtl/hub_ptr_bank.sv
module hub_ptr_bank #(
    parameter int AW    = 20,
    parameter int NPTR  = 2,
    localparam int SELW = (NPTR > 1) ? $clog2(NPTR) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPTR-1:0]      ld_en,
    input  logic [NPTR-1:0][AW-1:0] ld_val,
    input  logic                 upd_en,
    input  logic [SELW-1:0]      upd_sel,
    input  logic [AW-1:0]        upd_val,
    output logic [NPTR-1:0][AW-1:0] ptr
);

    typedef struct packed {
        logic [NPTR-1:0][AW-1:0] p;
        logic                    past_ok;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.past_ok = 1'b1;
        for (int i = 0; i < NPTR; i++) begin
            if (ld_en[i])
                st_d.p[i] = ld_val[i];
            else if (upd_en && (upd_sel == SELW'(i)))
                st_d.p[i] = upd_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr = st_q.p;

    generate
        for (genvar g = 0; g < NPTR; g++) begin : g_chk
            // R9
            ld_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.past_ok && $past(ld_en[g]) |-> ptr[g] == $past(ld_val[g]));
            // R10
            ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.past_ok && !$past(ld_en[g]) &&
                !($past(upd_en) && $past(upd_sel) == SELW'(g)) |-> $stable(ptr[g]));
        end
    endgenerate

endmodule

// File: rtl/hub_ea_gen.sv
module hub_ea_gen
    import hub_ea_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic [8:0]    acc_field,
    input  logic [1:0]    acc_size,
    input  logic          ld_a_en,
    input  logic [AW-1:0] ld_a_val,
    input  logic          ld_b_en,
    input  logic [AW-1:0] ld_b_val,
    output logic [AW-1:0] ea,
    output logic          ptr_we,
    output logic          ptr_wsel,
    output logic [AW-1:0] ptr_new
);

    opnd_dec_t            dec;
    logic [AW-1:0]        off;
    logic [1:0][AW-1:0]   ptr;
    logic [AW-1:0]        cur;
    logic [AW-1:0]        sum;
    logic                 chk_ok_q;

    hub_ea_decode u_dec (
        .opnd (acc_field),
        .dec  (dec)
    );

    hub_ea_offset #(.AW(AW)) u_off (
        .idx  (dec.idx),
        .size (acc_size),
        .off  (off)
    );

    hub_ptr_bank #(.AW(AW), .NPTR(2)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   ({ld_b_en, ld_a_en}),
        .ld_val  ({ld_b_val, ld_a_val}),
        .upd_en  (ptr_we),
        .upd_sel (ptr_wsel),
        .upd_val (ptr_new),
        .ptr     (ptr)
    );

    always_comb begin
        cur      = ptr[dec.sel];
        sum      = cur + off;
        ptr_we   = acc_valid && dec.is_ptr && dec.upd;
        ptr_wsel = dec.sel;
        ptr_new  = sum;
        if (!dec.is_ptr)
            ea = AW'(dec.abs_addr);
        else if (dec.upd && dec.post)
            ea = cur;
        else
            ea = sum;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chk_ok_q <= 1'b0;
        else        chk_ok_q <= 1'b1;
    end

    // R1
    abs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_field[8] |-> (ea < AW'(256)) && !ptr_we);
    // R10
    idle_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !ptr_we);
    // R4
    post_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_field[8] && acc_field[6] && acc_field[5] |->
        ea == (acc_field[7] ? ptr[1] : ptr[0]));
    // R5
    pre_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_ok_q && $past(ptr_we) && !$past(acc_field[5]) &&
        !($past(acc_field[7]) ? $past(ld_b_en) : $past(ld_a_en)) |->
        ($past(acc_field[7]) ? ptr[1] : ptr[0]) == $past(ea));

endmodule

// File: tb/hub_ea_gen_tb.sv
`timescale 1ns/1ps
module hub_ea_gen_tb_top;

    localparam int AW = 20;
    localparam logic [AW-1:0] MSK = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [8:0]    acc_field = '0;
    logic [1:0]    acc_size = '0;
    logic          ld_a_en = 1'b0, ld_b_en = 1'b0;
    logic [AW-1:0] ld_a_val = '0, ld_b_val = '0;
    logic [AW-1:0] ea, ptr_new;
    logic          ptr_we, ptr_wsel;

    int n_chk = 0, n_fail = 0;
    logic [AW-1:0] pa = '0, pb = '0;

    always #2.5 clk = ~clk;

    hub_ea_gen #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_field(acc_field),
        .acc_size(acc_size), .ld_a_en(ld_a_en), .ld_a_val(ld_a_val),
        .ld_b_en(ld_b_en), .ld_b_val(ld_b_val), .ea(ea), .ptr_we(ptr_we),
        .ptr_wsel(ptr_wsel), .ptr_new(ptr_new)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] pf(input bit s, input bit u, input bit p, input logic [4:0] idx);
        return {1'b1, s, u, p, idx};
    endfunction

    function automatic logic [AW-1:0] offs(input logic [4:0] idx, input logic [1:0] sz);
        logic [AW-1:0] e;
        e = {{(AW-5){idx[4]}}, idx};
        case (sz)
            2'd0: return e;
            2'd1: return (e * 2) & MSK;
            default: return (e * 4) & MSK;
        endcase
    endfunction

    // drive an access for one cycle; expected values checked before the edge
    task automatic access(input string req, input logic [8:0] f, input logic [1:0] sz,
                          input logic [AW-1:0] exp_ea, input bit exp_we);
        @(negedge clk);
        acc_valid = 1'b1; acc_field = f; acc_size = sz;
        #1;
        check({req, " ea"}, 32'(ea), 32'(exp_ea));
        check({req, " we"}, 32'(ptr_we), 32'(exp_we));
        @(posedge clk);
        #1 acc_valid = 1'b0;
    endtask

    task automatic peek(input string req, input bit s, input logic [AW-1:0] exp);
        @(negedge clk);
        acc_valid = 1'b0; acc_field = pf(s, 1'b0, 1'b0, 5'd0); acc_size = 2'd0;
        #1 check({req, " pointer"}, 32'(ea), 32'(exp));
    endtask

    task automatic load(input bit a_en, input logic [AW-1:0] av, input bit b_en, input logic [AW-1:0] bv);
        @(negedge clk);
        ld_a_en = a_en; ld_a_val = av; ld_b_en = b_en; ld_b_val = bv;
        @(posedge clk);
        #1 ld_a_en = 1'b0; ld_b_en = 1'b0;
        if (a_en) pa = av;
        if (b_en) pb = bv;
    endtask

    task automatic t_reset;
        peek("R11 A", 1'b0, '0);
        peek("R11 B", 1'b1, '0);
    endtask

    task automatic t_abs;
        access("R1 abs AB", 9'h0AB, 2'd2, AW'(8'hAB), 1'b0);
        access("R1 abs FF", 9'h0FF, 2'd0, AW'(8'hFF), 1'b0);
    endtask

    task automatic t_index;
        load(1'b1, 20'h00100, 1'b1, 20'h80000);
        access("R3 A+3 long", pf(0,0,0,5'd3), 2'd2, pa + 20'd12, 1'b0);
        access("R6 R3 B-1 byte", pf(1,0,0,5'b11111), 2'd0, pb - 20'd1, 1'b0);
        access("R7 A+5 word", pf(0,0,0,5'd5), 2'd1, pa + 20'd10, 1'b0);
        access("R7 size3 A+1", pf(0,0,0,5'd1), 2'd3, pa + 20'd4, 1'b0);
        peek("R3 A unchanged", 1'b0, pa);
    endtask

    task automatic t_post;
        access("R4 post A+1 byte", pf(0,1,1,5'd1), 2'd0, pa, 1'b1);
        pa = pa + 20'd1;
        peek("R4 A after", 1'b0, pa);
        @(negedge clk);
        acc_valid = 1'b1; acc_field = pf(1,1,1,5'b11111); acc_size = 2'd1;
        #1 check("R2 wsel B", 32'(ptr_wsel), 32'd1);
        check("R6 post B-1 word new", 32'(ptr_new), 32'(pb - 20'd2));
        @(posedge clk);
        #1 acc_valid = 1'b0;
        pb = pb - 20'd2;
        peek("R6 B after", 1'b1, pb);
        peek("R2 A untouched", 1'b0, pa);
    endtask

    task automatic t_pre;
        access("R5 pre B+2 long", pf(1,1,0,5'd2), 2'd2, pb + 20'd8, 1'b1);
        pb = pb + 20'd8;
        peek("R5 B after", 1'b1, pb);
    endtask

    task automatic t_b2b;
        access("R12 first", pf(0,1,1,5'd1), 2'd2, pa, 1'b1);
        pa = pa + 20'd4;
        access("R12 second", pf(0,1,1,5'd1), 2'd2, pa, 1'b1);
        pa = pa + 20'd4;
        peek("R12 A final", 1'b0, pa);
    endtask

    task automatic t_wrap;
        load(1'b1, 20'hFFFFE, 1'b1, 20'h00000);
        access("R8 pre A wrap", pf(0,1,0,5'd1), 2'd2, 20'h00002, 1'b1);
        pa = 20'h00002;
        access("R8 post B under", pf(1,1,1,5'b11111), 2'd0, 20'h00000, 1'b1);
        pb = 20'hFFFFF;
        peek("R8 A", 1'b0, pa);
        peek("R8 B", 1'b1, pb);
    endtask

    task automatic t_prio;
        @(negedge clk);
        acc_valid = 1'b1; acc_field = pf(0,1,1,5'd7); acc_size = 2'd0;
        ld_a_en = 1'b1; ld_a_val = 20'h12345;
        @(posedge clk);
        #1 acc_valid = 1'b0; ld_a_en = 1'b0;
        pa = 20'h12345;
        peek("R9 load wins", 1'b0, pa);
        @(negedge clk);
        acc_valid = 1'b1; acc_field = pf(1,1,0,5'd1); acc_size = 2'd0;
        ld_a_en = 1'b1; ld_a_val = 20'h00AAA;
        @(posedge clk);
        #1 acc_valid = 1'b0; ld_a_en = 1'b0;
        pa = 20'h00AAA; pb = pb + 20'd1;
        peek("R9 A loaded", 1'b0, pa);
        peek("R9 B updated", 1'b1, pb);
    endtask

    task automatic t_idle;
        @(negedge clk);
        acc_valid = 1'b0; acc_field = pf(0,1,0,5'd3); acc_size = 2'd2;
        #1 check("R10 idle we", 32'(ptr_we), 32'd0);
        @(posedge clk);
        peek("R10 A kept", 1'b0, pa);
    endtask

    initial begin : watchdog
        #(100000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_abs();
        t_index();
        t_post();
        t_pre();
        t_b2b();
        t_wrap();
        t_prio();
        t_idle();
        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule